// File: doc/BRIEF.md
# Dual-Expiry Watchdog with Shared Timebase

This block pairs a free-running up counter with a watchdog that takes its timeout from the same counter. Software reaches it through a 32-bit AXI4-Lite slave with a 4-bit address. The counter advances on every clock. It can be read in full, and a coarser copy sits in the control word, so a single read returns both the watchdog state and the time.

The watchdog works in two stages. The first interval expiry sets a state flag and raises a level interrupt. Software services the watchdog by writing 1 to that flag. If a second expiry arrives before the flag is cleared, the block raises its reset output. The reset output stays high until the system reset is applied. A reset-cause flag survives the system reset and clears only on a separate power-on reset or by software.

The watchdog runs while either of two enable bits is set. The two bits live at different addresses, so a single stray write cannot stop it. A parameter can lock the watchdog on once it has been enabled. A freeze input stalls all counting, for example while a debugger halts the system.

Top module: `dual_expiry_wdog`

## Requirements
- R1: The timebase (TB_W bits, default 32) increments by one on every clock. It is cleared by system reset and on the clock edge where the watchdog goes from disabled to enabled. Reading offset 0x8 returns it zero-extended.
- R2: `tb_irq` is high for exactly one cycle: the cycle after the timebase wraps from all ones to zero. It does not pulse when an enable clears the count.
- R3: While the watchdog is enabled, an expiry occurs every 2^INTERVAL_EXP cycles: on each edge where the low INTERVAL_EXP timebase bits are all ones and the carry reaches bit INTERVAL_EXP. An expiry with the state flag clear sets the flag and `wd_irq`, which is the flag itself.
- R4: An expiry while the state flag is set drives `wd_reset` high. It stays high until `rst_n` is low at a clock edge. The same event sets the reset-cause flag.
- R5: The state flag (bit 2 at 0x0) and the reset-cause flag (bit 3 at 0x0) clear when 1 is written to them. Writing 0 leaves them unchanged. An expiry on the same edge as a clearing write wins.
- R6: Reading 0x0 returns timebase bits [TB_W-1:4] in bits [TB_W-1:4], the reset-cause flag in bit 3, the state flag in bit 2, enable A in bit 1 and a read-only copy of enable B in bit 0.
- R7: Offset 0x4 holds enable B in bit 0. It is write-only and reads as zero. Writes to 0x8 change nothing.
- R8: The watchdog is enabled when enable A or enable B is 1. It is disabled only when both are 0. While disabled, no expiry occurs.
- R9: With ENABLE_ONCE=1, once the watchdog is enabled, writes of 0 to either enable bit are ignored. The watchdog can no longer be disabled, short of a system reset.
- R10: The reset-cause flag keeps its value through `rst_n` and is cleared only by `por_n` low or by a software clear.
- R11: While `freeze` is high, the timebase holds its value, no expiry occurs and no rollover pulse is produced.
- R12: All responses are OKAY (00). `awready` and `wready` are high together, only while both `awvalid` and `wvalid` are high and no write response is pending. A write changes the control bits only when `wstrb[0]` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | System reset, active low, synchronous |
| por_n | input | 1 | Power-on reset for the reset-cause flag, active low |
| freeze | input | 1 | Stalls the timebase and watchdog |
| awaddr | input | ADDR_W | Write address |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address ready |
| wdata | input | DATA_W | Write data |
| wstrb | input | DATA_W/8 | Write byte strobes |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data ready |
| bresp | output | 2 | Write response |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Write response ready |
| araddr | input | ADDR_W | Read address |
| arvalid | input | 1 | Read address valid |
| arready | output | 1 | Read address ready |
| rdata | output | DATA_W | Read data |
| rresp | output | 2 | Read response |
| rvalid | output | 1 | Read data valid |
| rready | input | 1 | Read data ready |
| tb_irq | output | 1 | Timebase rollover pulse |
| wd_irq | output | 1 | Watchdog first-expiry interrupt (level) |
| wd_reset | output | 1 | Watchdog reset request |

## Verification
The assertions assume that `rst_n` is low for at least one clock edge before any check counts. They also assume a master keeps `bready` high or only holds a response it has not yet taken, so a pending response is never dropped by the block on its own. The stimulus always asserts `awvalid` and `wvalid` together, drops them right after the accepting edge and keeps `bready` and `rready` high. Inputs change only on the falling edge.

// File: rtl/dual_expiry_wdog.sv
module dual_expiry_wdog #(
  parameter int TB_W         = 32,
  parameter int INTERVAL_EXP = 30,
  parameter bit ENABLE_ONCE  = 1'b1,
  parameter int ADDR_W       = 4,
  parameter int DATA_W       = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                por_n,
  input  logic                freeze,
  input  logic [ADDR_W-1:0]   awaddr,
  input  logic                awvalid,
  output logic                awready,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [DATA_W/8-1:0] wstrb,
  input  logic                wvalid,
  output logic                wready,
  output logic [1:0]          bresp,
  output logic                bvalid,
  input  logic                bready,
  input  logic [ADDR_W-1:0]   araddr,
  input  logic                arvalid,
  output logic                arready,
  output logic [DATA_W-1:0]   rdata,
  output logic [1:0]          rresp,
  output logic                rvalid,
  input  logic                rready,
  output logic                tb_irq,
  output logic                wd_irq,
  output logic                wd_reset
);

  localparam logic [TB_W-1:0] TB_TOP = '1;
  localparam logic [1:0] SEL_CSR0 = 2'd0;
  localparam logic [1:0] SEL_CSR1 = 2'd1;
  localparam logic [1:0] SEL_TB   = 2'd2;

  logic [TB_W-1:0]   tb;
  logic              en_a, en_b, wds, wrs, wrst, tb_wrap;
  logic              bvalid_q, rvalid_q;
  logic [DATA_W-1:0] rdata_q;

  wire wr_go   = awvalid && wvalid && !bvalid_q;
  wire wr_lane = wr_go && wstrb[0];
  wire wr_csr0 = wr_lane && (awaddr[3:2] == SEL_CSR0);
  wire wr_csr1 = wr_lane && (awaddr[3:2] == SEL_CSR1);
  wire wd_en   = en_a | en_b;
  wire lock    = ENABLE_ONCE && wd_en;

  wire en_a_nx = (wr_csr0 ? wdata[1] : en_a) | (lock & en_a);
  wire en_b_nx = (wr_csr1 ? wdata[0] : en_b) | (lock & en_b);
  wire en_rise = (en_a_nx | en_b_nx) && !wd_en;
  wire expire  = wd_en && !freeze && (&tb[INTERVAL_EXP-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tb      <= '0;
      tb_wrap <= 1'b0;
      en_a    <= 1'b0;
      en_b    <= 1'b0;
      wds     <= 1'b0;
      wrst    <= 1'b0;
    end else begin
      tb_wrap <= !freeze && !en_rise && (tb == TB_TOP);
      if (en_rise)      tb <= '0;
      else if (!freeze) tb <= tb + 1'b1;
      en_a <= en_a_nx;
      en_b <= en_b_nx;
      if (expire)                    wds <= 1'b1;
      else if (wr_csr0 && wdata[2])  wds <= 1'b0;
      if (expire && wds) wrst <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!por_n)                        wrs <= 1'b0;
    else if (rst_n) begin
      if (expire && wds)               wrs <= 1'b1;
      else if (wr_csr0 && wdata[3])    wrs <= 1'b0;
    end
  end

  logic [DATA_W-1:0] tb_word, csr0_word, rd_mux;
  assign tb_word   = DATA_W'(tb);
  assign csr0_word = {tb_word[DATA_W-1:4], wrs, wds, en_a, en_b};
  always_comb begin
    case (araddr[3:2])
      SEL_CSR0: rd_mux = csr0_word;
      SEL_TB:   rd_mux = tb_word;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bvalid_q <= 1'b0;
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      if (wr_go)       bvalid_q <= 1'b1;
      else if (bready) bvalid_q <= 1'b0;
      if (arvalid && !rvalid_q) begin
        rvalid_q <= 1'b1;
        rdata_q  <= rd_mux;
      end else if (rready) rvalid_q <= 1'b0;
    end
  end

  assign awready  = wr_go;
  assign wready   = wr_go;
  assign bvalid   = bvalid_q;
  assign bresp    = 2'b00;
  assign arready  = !rvalid_q;
  assign rvalid   = rvalid_q;
  assign rdata    = rdata_q;
  assign rresp    = 2'b00;
  assign tb_irq   = tb_wrap;
  assign wd_irq   = wds;
  assign wd_reset = wrst;

  wire unused_bits = ^{wdata, wstrb, awaddr, araddr};

  // R2
  wrap_lands_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tb_irq |-> (tb == '0));
  // R4
  reset_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_reset |=> wd_reset);
  // R4
  reset_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_reset) |-> $past(wds));
  // R3
  flag_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wds) |-> $past(wd_en));
  // R11
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !en_rise) |=> $stable(tb));
  // R12
  resp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bvalid && !bready) |=> bvalid);

  generate
    if (ENABLE_ONCE) begin : g_once
      // R9
      lock_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wd_en |=> wd_en);
    end
  endgenerate

endmodule

// File: tb/test_dual_expiry_wdog.sv
module test_dual_expiry_wdog;
  localparam int TB_W = 12;
  localparam int NEXP = 8;

  logic clk = 0, rst_n = 0, por_n = 0, freeze = 0;
  logic [3:0] awaddr = 0, araddr = 0;
  logic awvalid = 0, wvalid = 0, bready = 1, arvalid = 0, rready = 1;
  logic [31:0] wdata = 0;
  logic [3:0] wstrb = 0;
  logic [1:0] awready, wready, bvalid, arready, rvalid, tb_irq, wd_irq, wd_rst;
  logic [1:0][1:0] bresp, rresp;
  logic [1:0][31:0] rdata;

  int n_chk = 0, n_fail = 0;
  always #4 clk = ~clk;

  dual_expiry_wdog #(.TB_W(TB_W), .INTERVAL_EXP(NEXP), .ENABLE_ONCE(1'b0)) i_dual_expiry_wdog (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .freeze(freeze),
    .awaddr(awaddr), .awvalid(awvalid), .awready(awready[0]), .wdata(wdata), .wstrb(wstrb),
    .wvalid(wvalid), .wready(wready[0]), .bresp(bresp[0]), .bvalid(bvalid[0]), .bready(bready),
    .araddr(araddr), .arvalid(arvalid), .arready(arready[0]), .rdata(rdata[0]), .rresp(rresp[0]),
    .rvalid(rvalid[0]), .rready(rready), .tb_irq(tb_irq[0]), .wd_irq(wd_irq[0]), .wd_reset(wd_rst[0]));

  dual_expiry_wdog #(.TB_W(TB_W), .INTERVAL_EXP(NEXP), .ENABLE_ONCE(1'b1)) i_dual_expiry_wdog_once (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .freeze(freeze),
    .awaddr(awaddr), .awvalid(awvalid), .awready(awready[1]), .wdata(wdata), .wstrb(wstrb),
    .wvalid(wvalid), .wready(wready[1]), .bresp(bresp[1]), .bvalid(bvalid[1]), .bready(bready),
    .araddr(araddr), .arvalid(arvalid), .arready(arready[1]), .rdata(rdata[1]), .rresp(rresp[1]),
    .rvalid(rvalid[1]), .rready(rready), .tb_irq(tb_irq[1]), .wd_irq(wd_irq[1]), .wd_reset(wd_rst[1]));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model, one slot per instance (slot 1 is enable-once)
  logic [TB_W-1:0] m_tb[2];
  logic m_en1[2], m_en2[2], m_wds[2], m_wrs[2], m_rst[2], m_tbi[2], m_bv[2], m_rv[2];
  logic [31:0] m_rd[2];
  logic wacc, racc, c0, c1, eold, n1, n2, rise, ev, wold;

  initial for (int k = 0; k < 2; k++) begin
    m_tb[k] = 0; m_en1[k] = 0; m_en2[k] = 0; m_wds[k] = 0; m_wrs[k] = 0;
    m_rst[k] = 0; m_tbi[k] = 0; m_bv[k] = 0; m_rv[k] = 0; m_rd[k] = 0;
  end

  always @(posedge clk) begin
    for (int k = 0; k < 2; k++) begin
      if (!rst_n) begin
        m_tb[k] = 0; m_en1[k] = 0; m_en2[k] = 0; m_wds[k] = 0; m_rst[k] = 0;
        m_tbi[k] = 0; m_bv[k] = 0; m_rv[k] = 0; m_rd[k] = 0;
      end else begin
        wacc = awvalid && wvalid && !m_bv[k];
        racc = arvalid && !m_rv[k];
        c0 = wacc && wstrb[0] && awaddr[3:2] == 2'd0;
        c1 = wacc && wstrb[0] && awaddr[3:2] == 2'd1;
        eold = m_en1[k] | m_en2[k];
        n1 = c0 ? wdata[1] : m_en1[k];
        n2 = c1 ? wdata[0] : m_en2[k];
        if (k == 1 && eold) begin n1 = n1 | m_en1[k]; n2 = n2 | m_en2[k]; end
        rise = (n1 | n2) && !eold;
        ev = eold && !freeze && (m_tb[k] % (1 << NEXP)) == (1 << NEXP) - 1;
        wold = m_wds[k];
        if (racc) begin
          if (araddr[3:2] == 2'd0)
            m_rd[k] = {20'h0, m_tb[k][TB_W-1:4], m_wrs[k], wold, m_en1[k], m_en2[k]};
          else if (araddr[3:2] == 2'd2) m_rd[k] = {20'h0, m_tb[k]};
          else m_rd[k] = 0;
          m_rv[k] = 1;
        end else if (rready) m_rv[k] = 0;
        if (wacc) m_bv[k] = 1; else if (bready) m_bv[k] = 0;
        m_tbi[k] = !freeze && !rise && m_tb[k] == {TB_W{1'b1}};
        if (rise) m_tb[k] = 0; else if (!freeze) m_tb[k] = m_tb[k] + 1'b1;
        if (ev) m_wds[k] = 1; else if (c0 && wdata[2]) m_wds[k] = 0;
        if (ev && wold) m_rst[k] = 1;
        if (ev && wold) m_wrs[k] = 1; else if (c0 && wdata[3]) m_wrs[k] = 0;
        m_en1[k] = n1; m_en2[k] = n2;
      end
      if (!por_n) m_wrs[k] = 0;
    end
  end

  always @(posedge clk) begin
    #1;
    for (int k = 0; k < 2; k++) begin
      chk(tb_irq[k] === m_tbi[k], "R2 tb_irq", tb_irq[k], m_tbi[k]);
      chk(wd_irq[k] === m_wds[k], "R3 wd_irq", wd_irq[k], m_wds[k]);
      chk(wd_rst[k] === m_rst[k], "R4 wd_reset", wd_rst[k], m_rst[k]);
      chk(awready[k] === (awvalid && wvalid && !m_bv[k]) && wready[k] === awready[k],
          "R12 awready/wready", {awready[k], wready[k]}, {2{awvalid && wvalid && !m_bv[k]}});
      chk(bvalid[k] === m_bv[k] && rvalid[k] === m_rv[k], "R12 bvalid/rvalid",
          {bvalid[k], rvalid[k]}, {m_bv[k], m_rv[k]});
      chk(bresp[k] === 2'b00 && rresp[k] === 2'b00, "R12 resp OKAY", {bresp[k], rresp[k]}, 0);
      if (m_rv[k]) chk(rdata[k] === m_rd[k], "R6 rdata", rdata[k], m_rd[k]);
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    awaddr = a; wdata = d; wstrb = s; awvalid = 1; wvalid = 1;
    @(negedge clk);
    awvalid = 0; wvalid = 0;
    @(negedge clk);
  endtask

  logic [31:0] rd0, rd1;
  task automatic rd(input logic [3:0] a);
    @(negedge clk);
    araddr = a; arvalid = 1;
    @(negedge clk);
    arvalid = 0; rd0 = rdata[0]; rd1 = rdata[1];
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  logic [31:0] hold0;
  bit done = 0;

  initial begin
    idle(3);
    por_n = 1; rst_n = 1;
    // R1 reset state, no watchdog activity while disabled (R8), wrap pulse (R2)
    rd(4'h0);
    chk(rd0[3:0] == 4'h0, "R1 reset csr0 flags", rd0[3:0], 0);
    idle(4200);
    chk(wd_irq == 2'b00, "R8 disabled no expiry", wd_irq, 0);
    // R7 enable B at 0x4, clears timebase (R1)
    wr(4'h4, 32'h1, 4'hF);
    rd(4'h8);
    chk(rd0 < 32'd8 && rd1 < 32'd8, "R1 timebase cleared on enable", rd0, 0);
    rd(4'h0);
    chk(rd0[0] == 1'b1 && rd0[1] == 1'b0, "R6 enable B mirrored in bit 0", rd0[1:0], 1);
    rd(4'h4);
    chk(rd0 == 0, "R7 0x4 reads zero", rd0, 0);
    idle(300);
    chk(wd_irq == 2'b11 && wd_rst == 2'b00, "R3 first expiry", {wd_irq, wd_rst}, 4'b1100);
    // R5 write-one clear
    wr(4'h0, 32'h4, 4'hF);
    chk(wd_irq == 2'b00, "R5 W1C state flag", wd_irq, 0);
    idle(260);
    chk(wd_irq == 2'b11, "R3 second interval flags again", wd_irq, 3);
    wr(4'h0, 32'h0, 4'hF);
    chk(wd_irq == 2'b11, "R5 write zero keeps flag", wd_irq, 3);
    idle(260);
    chk(wd_rst == 2'b11, "R4 unserviced expiry resets", wd_rst, 3);
    rd(4'h0);
    chk(rd0[3] == 1'b1, "R4 reset-cause set", rd0[3], 1);
    // R7 writes to 0x8 ignored
    rd(4'h8); hold0 = rd0;
    wr(4'h8, 32'h0, 4'hF);
    rd(4'h8);
    chk(rd0 == hold0 + 32'd6, "R7 timebase write ignored", rd0, hold0 + 32'd6);
    // R11 freeze
    @(negedge clk); freeze = 1;
    rd(4'h8); hold0 = rd0;
    idle(500);
    rd(4'h8);
    chk(rd0 == hold0, "R11 frozen timebase", rd0, hold0);
    @(negedge clk); freeze = 0;
    // R10 reset-cause survives system reset, wd_reset released (R4)
    @(negedge clk); rst_n = 0;
    idle(2);
    rst_n = 1;
    chk(wd_rst == 2'b00, "R4 reset output released", wd_rst, 0);
    rd(4'h0);
    chk(rd0[3:0] == 4'b1000, "R10 reset-cause kept", rd0[3:0], 4'b1000);
    wr(4'h0, 32'h8, 4'hF);
    rd(4'h0);
    chk(rd0[3] == 1'b0, "R5 W1C reset-cause", rd0[3], 0);
    // R12 byte lane 0 off: ignored
    wr(4'h0, 32'h2, 4'hE);
    rd(4'h0);
    chk(rd0[1] == 1'b0, "R12 strobe gates write", rd0[1], 0);
    // R9 enable-once vs. R8 enable-disable
    wr(4'h0, 32'h2, 4'hF);
    wr(4'h0, 32'h0, 4'hF);
    rd(4'h0);
    chk(rd0[1] == 1'b0 && rd1[1] == 1'b1, "R9 disable blocked when locked", {rd0[1], rd1[1]}, 2'b01);
    idle(600);
    chk(wd_rst == 2'b10, "R9 locked instance still expires", wd_rst, 2'b10);
    chk(wd_irq[0] == 1'b0, "R8 both enables off", wd_irq[0], 0);
    // R10 power-on reset clears reset-cause
    @(negedge clk); por_n = 0; rst_n = 0;
    idle(2);
    por_n = 1; rst_n = 1;
    rd(4'h0);
    chk(rd1[3] == 1'b0, "R10 por clears reset-cause", rd1[3], 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog timeout");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule